// File: doc/BRIEF.md
# Instruction Cache Read Path with Sequential Way Gating

This block is the read side of a four-way set-associative level-one instruction cache. The cache is indexed and tagged by physical address. Each fetch request returns up to 16 bytes. The bytes returned run from the request address up to the next 16-byte aligned boundary. Because a 16-byte aligned chunk always lies inside one 64-byte line and one 4 KB page, clipping at that boundary also keeps every fetch inside its line and its page. Bytes past the boundary are flagged as not returned.

To save power, the block keeps a small tracking record: the line address of the last hit, the way it hit in, and a valid flag. A fetch that falls in that same tracked line is treated as sequential. For a sequential fetch, only the data array of the remembered way is enabled, and no tag array is enabled. Any other fetch performs a full lookup, which enables all tag ways and all data ways. The enable strobes leave the block so that array activations can be counted.

A clear control enable bit shuts the arrays off completely. While the bit is clear, every fetch misses, but invalidation still works. Lines enter the cache through a whole-line fill port. The fill writes the way chosen by a round-robin pointer kept for each set.

Requests use a valid/ready handshake. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending, or when the pending response is taken in the same cycle. A response stays valid, with its content unchanged, until `rsp_ready` is seen high. The control, fill and maintenance pins are plain single-cycle strobes.

Top module: `icache_seq_fetch`

## Requirements
- R1: A request accepted at a clock edge gives `rsp_valid` high after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold stable.
- R2: Let o = address bits [3:0] and c = bits [5:4]. On a hit, `rsp_bytes` has bits 0 to 15-o set. Byte i of `rsp_data` equals byte 16c+o+i of the line for each set bit, and zero elsewhere. On a miss, `rsp_bytes` and `rsp_data` are zero.
- R3: An accepted, enabled fetch that is not sequential drives `tag_rd_en` and `data_rd_en` to all ones in its acceptance cycle.
- R4: A fetch is sequential when all of the following hold: the tracker is valid, `pipe_flush` is low, and address bits [31:6] equal the tracked line. A sequential fetch drives `tag_rd_en` to zero and `data_rd_en` to the one-hot code of the tracked way, and it reports a hit.
- R5: A full lookup hits when some valid way of set bits [9:6] holds tag bits [31:10]. If several ways match, the lowest-numbered way supplies the data.
- R6: While `ctl_enable` is low, both enable vectors stay zero and every fetch reports a miss.
- R7: A fill writes the line into way `rr[set]` of its set and marks that way valid. The pointer `rr[set]` then advances by one, modulo 4. Every pointer resets to way 0.
- R8: `inv_all` clears every valid bit. A fill in the same cycle is dropped.
- R9: An invalidate by line address clears the way that matches the line, and it does so even while `ctl_enable` is low.
- R10: Any of the following clears the tracker, so the next fetch to the same line does a full lookup: a miss, a fill, any invalidate, a change of `ctl_enable`, or a `pipe_flush`.
- R11: In a cycle with no accepted request, both enable vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Cache enable from the control register |
| pipe_flush | input | 1 | Pipeline flush; clears sequential tracking |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request can be accepted |
| req_addr | input | 32 | Physical fetch byte address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Fetch hit |
| rsp_data | output | 128 | Fetched bytes, first byte in bits [7:0] |
| rsp_bytes | output | 16 | Mask of returned bytes |
| tag_rd_en | output | 4 | Per-way tag array enable |
| data_rd_en | output | 4 | Per-way data array enable |
| fill_valid | input | 1 | Line fill strobe |
| fill_line | input | 26 | Line address (bits [31:6]) of the fill |
| fill_data | input | 512 | Fill line, byte 0 in bits [7:0] |
| inv_all | input | 1 | Invalidate the whole cache |
| inv_valid | input | 1 | Invalidate by line address |
| inv_line | input | 26 | Line address to invalidate |

## Verification
Suppose the tracker is left valid after a fill or an invalidate. The next fetch to that line then shows a one-hot `data_rd_en` and a zero `tag_rd_en` in its own acceptance cycle, where all ones are expected. It can also return stale bytes one cycle later. A wrong round-robin pointer or a lost valid bit does not show up at the fill itself. It shows up only on a later fetch, as a hit or miss that the bench model does not expect. For that reason, the random mix deliberately fills more than four lines into a few sets, so that evictions happen and such errors reach the ports. A slip in the chunk or offset arithmetic shows up in `rsp_bytes` and `rsp_data` in the cycle right after the request is accepted.

// File: rtl/icw_pkg.sv
package icw_pkg;
  localparam int LINE_BYTES  = 64;
  localparam int FETCH_BYTES = 16;
  localparam int OFS_W       = $clog2(LINE_BYTES);
  localparam int FOFS_W      = $clog2(FETCH_BYTES);
  localparam int LINE_BITS   = LINE_BYTES * 8;
  localparam int FETCH_BITS  = FETCH_BYTES * 8;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_FULL = 2'd1,
    LK_SEQ  = 2'd2
  } lookup_kind_e;
endpackage

// File: rtl/icw_tag_store.sv
module icw_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   lk_set,
  input  logic [TAG_W-1:0]          lk_tag,
  input  logic [WAYS-1:0]           tag_en,
  output logic                      hit_any,
  output logic [$clog2(WAYS)-1:0]   hit_way,
  input  logic                      fill_valid,
  input  logic [$clog2(SETS)-1:0]   fill_set,
  input  logic [TAG_W-1:0]          fill_tag,
  output logic [$clog2(WAYS)-1:0]   fill_way,
  input  logic                      inv_all,
  input  logic                      inv_valid,
  input  logic [$clog2(SETS)-1:0]   inv_set,
  input  logic [TAG_W-1:0]          inv_tag
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [WAYS-1:0]  vld  [SETS];
  logic [WAY_W-1:0] rr   [SETS];
  logic [WAYS-1:0]  hit_vec;
  logic             any_valid;
  logic             do_fill;

  assign do_fill  = fill_valid && !inv_all;
  assign fill_way = rr[fill_set];

  always_comb begin
    hit_vec = '0;
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = tag_en[w] && vld[lk_set][w] && (tags[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit_any = |hit_vec;

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
    end else if (inv_all) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      if (fill_valid) begin
        vld[fill_set][rr[fill_set]] <= 1'b1;
        rr[fill_set] <= rr[fill_set] + 1'b1;
      end
      if (inv_valid) begin
        for (int w = 0; w < WAYS; w++)
          if (vld[inv_set][w] && tags[inv_set][w] == inv_tag)
            vld[inv_set][w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) tags[fill_set][rr[fill_set]] <= fill_tag;
  end

  AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && !inv_valid) |=> vld[$past(fill_set)][$past(fill_way)]); // R7
  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_valid); // R8
endmodule

// File: rtl/icw_data_store.sv
module icw_data_store #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                                     clk,
  input  logic [WAYS-1:0]                          rd_en,
  input  logic [$clog2(SETS)-1:0]                  rd_set,
  output logic [WAYS-1:0][icw_pkg::LINE_BITS-1:0]  rd_lines,
  input  logic                                     wr_en,
  input  logic [$clog2(SETS)-1:0]                  wr_set,
  input  logic [$clog2(WAYS)-1:0]                  wr_way,
  input  logic [icw_pkg::LINE_BITS-1:0]            wr_data
);
  localparam int WAY_W = $clog2(WAYS);

  logic [icw_pkg::LINE_BITS-1:0] mem [SETS*WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_set, wr_way}] <= wr_data;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rd_lines[w] = rd_en[w] ? mem[{rd_set, WAY_W'(w)}] : '0;
  end
endmodule

// File: rtl/icw_seq_track.sv
module icw_seq_track #(
  parameter int LA_W = 26,
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     flush,
  input  logic                     maint,
  input  logic                     look,
  input  logic                     hit,
  input  logic [LA_W-1:0]          line,
  input  logic [$clog2(WAYS)-1:0]  way,
  output logic                     trk_valid,
  output logic [LA_W-1:0]          trk_line,
  output logic [$clog2(WAYS)-1:0]  trk_way
);
  logic en_q;
  logic clr;

  assign clr = flush || maint || (en != en_q) || (look && !hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      trk_valid <= 1'b0;
      trk_line  <= '0;
      trk_way   <= '0;
    end else begin
      en_q <= en;
      if (clr) begin
        trk_valid <= 1'b0;
      end else if (look && hit) begin
        trk_valid <= 1'b1;
        trk_line  <= line;
        trk_way   <= way;
      end
    end
  end

  AST_TRK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (maint || flush) |=> !trk_valid); // R10
endmodule

// File: rtl/icache_seq_fetch.sv
module icache_seq_fetch #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     ctl_enable,
  input  logic                                     pipe_flush,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic [ADDR_W-1:0]                        req_addr,
  output logic                                     rsp_valid,
  input  logic                                     rsp_ready,
  output logic                                     rsp_hit,
  output logic [icw_pkg::FETCH_BITS-1:0]           rsp_data,
  output logic [icw_pkg::FETCH_BYTES-1:0]          rsp_bytes,
  output logic [WAYS-1:0]                          tag_rd_en,
  output logic [WAYS-1:0]                          data_rd_en,
  input  logic                                     fill_valid,
  input  logic [ADDR_W-icw_pkg::OFS_W-1:0]         fill_line,
  input  logic [icw_pkg::LINE_BITS-1:0]            fill_data,
  input  logic                                     inv_all,
  input  logic                                     inv_valid,
  input  logic [ADDR_W-icw_pkg::OFS_W-1:0]         inv_line
);
  import icw_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LA_W  = ADDR_W - OFS_W;
  localparam int TAG_W = LA_W - SET_W;

  logic                          accept;
  logic [LA_W-1:0]               req_line;
  logic [FOFS_W-1:0]             req_off;
  logic [OFS_W-FOFS_W-1:0]       req_chunk;
  lookup_kind_e                  kind;
  logic                          hit_any, hit;
  logic [WAY_W-1:0]              hit_way, sel_way, fill_way;
  logic                          trk_valid;
  logic [LA_W-1:0]               trk_line;
  logic [WAY_W-1:0]              trk_way;
  logic [WAYS-1:0][LINE_BITS-1:0] rd_lines;
  logic [LINE_BITS-1:0]          line_sel;
  logic [FETCH_BITS-1:0]         chunk_bits, shifted;
  logic [FETCH_BYTES-1:0]        byte_mask;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign req_line  = req_addr[ADDR_W-1:OFS_W];
  assign req_off   = req_addr[FOFS_W-1:0];
  assign req_chunk = req_addr[OFS_W-1:FOFS_W];

  always_comb begin
    kind = LK_NONE;
    if (accept && ctl_enable)
      kind = (trk_valid && !pipe_flush && trk_line == req_line) ? LK_SEQ : LK_FULL;
  end

  always_comb begin
    tag_rd_en  = '0;
    data_rd_en = '0;
    case (kind)
      LK_FULL: begin
        tag_rd_en  = '1;
        data_rd_en = '1;
      end
      LK_SEQ:  data_rd_en = WAYS'(1) << trk_way;
      default: ;
    endcase
  end

  assign hit     = (kind == LK_SEQ) || (kind == LK_FULL && hit_any);
  assign sel_way = (kind == LK_SEQ) ? trk_way : hit_way;

  icw_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_set     (req_line[SET_W-1:0]),
    .lk_tag     (req_line[LA_W-1:SET_W]),
    .tag_en     (tag_rd_en),
    .hit_any    (hit_any),
    .hit_way    (hit_way),
    .fill_valid (fill_valid),
    .fill_set   (fill_line[SET_W-1:0]),
    .fill_tag   (fill_line[LA_W-1:SET_W]),
    .fill_way   (fill_way),
    .inv_all    (inv_all),
    .inv_valid  (inv_valid),
    .inv_set    (inv_line[SET_W-1:0]),
    .inv_tag    (inv_line[LA_W-1:SET_W])
  );

  icw_data_store #(.SETS(SETS), .WAYS(WAYS)) u_data (
    .clk      (clk),
    .rd_en    (data_rd_en),
    .rd_set   (req_line[SET_W-1:0]),
    .rd_lines (rd_lines),
    .wr_en    (fill_valid && !inv_all),
    .wr_set   (fill_line[SET_W-1:0]),
    .wr_way   (fill_way),
    .wr_data  (fill_data)
  );

  icw_seq_track #(.LA_W(LA_W), .WAYS(WAYS)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctl_enable),
    .flush     (pipe_flush),
    .maint     (fill_valid || inv_all || inv_valid),
    .look      (accept),
    .hit       (hit),
    .line      (req_line),
    .way       (sel_way),
    .trk_valid (trk_valid),
    .trk_line  (trk_line),
    .trk_way   (trk_way)
  );

  always_comb begin
    line_sel   = rd_lines[sel_way];
    chunk_bits = line_sel[int'(req_chunk)*FETCH_BITS +: FETCH_BITS];
    shifted    = chunk_bits >> {req_off, 3'b000};
    byte_mask  = {FETCH_BYTES{1'b1}} >> req_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      rsp_bytes <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= hit;
      rsp_data  <= hit ? shifted : '0;
      rsp_bytes <= hit ? byte_mask : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_DATA_EN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(data_rd_en) || (&data_rd_en))); // R3
  AST_SEQ_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ctl_enable && trk_valid && !pipe_flush && trk_line == req_line)
      |-> (tag_rd_en == '0 && $countones(data_rd_en) == 1)); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> (tag_rd_en == '0 && data_rd_en == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> (tag_rd_en == '0 && data_rd_en == '0)); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_bytes))); // R1
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_bytes == '0); // R2
endmodule

// File: tb/test_icache_seq_fetch.sv
module test_icache_seq_fetch;
  localparam int AW = 32;

  logic         clk, rst_n, ctl_enable, pipe_flush;
  logic         req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [31:0]  req_addr;
  logic [127:0] rsp_data;
  logic [15:0]  rsp_bytes;
  logic [3:0]   tag_rd_en, data_rd_en;
  logic         fill_valid, inv_all, inv_valid;
  logic [25:0]  fill_line, inv_line;
  logic [511:0] fill_data;

  icache_seq_fetch i_icache_seq_fetch (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .pipe_flush(pipe_flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data), .rsp_bytes(rsp_bytes), .tag_rd_en(tag_rd_en),
    .data_rd_en(data_rd_en), .fill_valid(fill_valid), .fill_line(fill_line),
    .fill_data(fill_data), .inv_all(inv_all), .inv_valid(inv_valid),
    .inv_line(inv_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  bit          mv  [16][4];
  logic [25:0] mla [16][4];
  int          mrr [16];
  bit          tv;
  logic [25:0] tline;
  int          tway;
  bit          men;

  function automatic logic [511:0] pat(input logic [25:0] la);
    logic [511:0] r;
    for (int j = 0; j < 64; j++)
      r[j*8 +: 8] = (la[7:0] * 8'd3) + (8'(j) * 8'd37) + (la[15:8] ^ 8'h5A) + la[23:16];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input bit fl);
    logic [25:0] la;
    int s, ew, o, c;
    bit seq, full, eh;
    logic [3:0] etag, edat;
    logic [15:0] emask;
    logic [127:0] edata;
    logic [511:0] ln;
    la = a[31:6]; s = int'(a[9:6]); o = int'(a[3:0]); c = int'(a[5:4]);
    seq = men && tv && !fl && tline == la;
    full = men && !seq;
    ew = 0; eh = 0;
    if (seq) begin
      eh = 1; ew = tway;
    end else if (full) begin
      for (int w = 3; w >= 0; w--)
        if (mv[s][w] && mla[s][w] == la) begin eh = 1; ew = w; end
    end
    etag = full ? 4'hF : 4'h0;
    edat = full ? 4'hF : (seq ? (4'b0001 << tway) : 4'h0);
    emask = eh ? (16'hFFFF >> o) : 16'h0;
    edata = '0;
    if (eh) begin
      ln = pat(mla[s][ew]);
      for (int i = 0; i < 16; i++)
        if (i < 16 - o) edata[i*8 +: 8] = ln[(c*16 + o + i)*8 +: 8];
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; pipe_flush = fl;
    #1;
    chk(req_ready == 1'b1, "R1 ready", 128'(req_ready), 128'(1));
    chk(tag_rd_en == etag, seq ? "R4 tag enable" : (men ? "R3 tag enable" : "R6 tag enable"),
        128'(tag_rd_en), 128'(etag));
    chk(data_rd_en == edat, seq ? "R4 data enable" : (men ? "R3 data enable" : "R6 data enable"),
        128'(data_rd_en), 128'(edat));
    @(posedge clk);
    #1;
    req_valid = 1'b0; pipe_flush = 1'b0;
    chk(rsp_valid == 1'b1, "R1 response valid", 128'(rsp_valid), 128'(1));
    chk(rsp_hit == eh, men ? "R5 hit" : "R6 miss", 128'(rsp_hit), 128'(eh));
    chk(rsp_bytes == emask, "R2 byte mask", 128'(rsp_bytes), 128'(emask));
    chk(rsp_data == edata, "R2 data", rsp_data, edata);
    if (fl || !eh) tv = 0;
    else begin tv = 1; tline = la; tway = ew; end
  endtask

  task automatic do_fill(input logic [25:0] la, input bit with_all);
    int s;
    s = int'(la[3:0]);
    @(negedge clk);
    fill_valid = 1'b1; fill_line = la; fill_data = pat(la); inv_all = with_all;
    @(posedge clk);
    #1;
    fill_valid = 1'b0; inv_all = 1'b0;
    if (with_all) begin
      for (int x = 0; x < 16; x++) for (int w = 0; w < 4; w++) mv[x][w] = 0;
    end else begin
      mv[s][mrr[s]] = 1; mla[s][mrr[s]] = la; mrr[s] = (mrr[s] + 1) % 4;
    end
    tv = 0;
  endtask

  task automatic do_inv(input logic [25:0] la);
    int s;
    s = int'(la[3:0]);
    @(negedge clk);
    inv_valid = 1'b1; inv_line = la;
    @(posedge clk);
    #1;
    inv_valid = 1'b0;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mla[s][w] == la) mv[s][w] = 0;
    tv = 0;
  endtask

  task automatic do_inv_all();
    @(negedge clk);
    inv_all = 1'b1;
    @(posedge clk);
    #1;
    inv_all = 1'b0;
    for (int x = 0; x < 16; x++) for (int w = 0; w < 4; w++) mv[x][w] = 0;
    tv = 0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    ctl_enable = v;
    @(posedge clk);
    #1;
    if (v != men) tv = 0;
    men = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  localparam logic [31:0] A0 = 32'h0040_1040;
  localparam logic [31:0] B0 = 32'h0080_2040;

  initial begin
    logic [127:0] held;
    logic [31:0] prev;
    void'($urandom(32'd4242));
    rst_n = 0; ctl_enable = 0; pipe_flush = 0; req_valid = 0; req_addr = '0;
    rsp_ready = 1; fill_valid = 0; fill_line = '0; fill_data = '0;
    inv_all = 0; inv_valid = 0; inv_line = '0;
    for (int x = 0; x < 16; x++) begin
      mrr[x] = 0;
      for (int w = 0; w < 4; w++) begin mv[x][w] = 0; mla[x][w] = '0; end
    end
    tv = 0; tline = '0; tway = 0; men = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 reset response", 128'(rsp_valid), 128'(0));
    chk(req_ready == 1, "R1 reset ready", 128'(req_ready), 128'(1));
    chk(tag_rd_en == 0 && data_rd_en == 0, "R11 reset enables",
        128'({tag_rd_en, data_rd_en}), 128'(0));

    set_en(1);
    fetch(A0, 0);                 // miss, full lookup
    do_fill(A0[31:6], 0);         // way 0 of set 1
    fetch(A0 + 32'h5, 0);         // full lookup after fill clear, hit
    fetch(A0 + 32'h14, 0);        // sequential, R4
    fetch(A0 + 32'h3F, 0);        // sequential, one byte, R2
    fetch(A0 + 32'h40, 0);        // other line, miss, R10 clears
    fetch(A0 + 32'h8, 0);         // full lookup after miss
    // R7 round robin: three more lines into set 1, then a fifth evicts A0
    do_fill(26'h0000_A01, 0);
    do_fill(26'h0000_B01, 0);
    do_fill(26'h0000_C01, 0);
    fetch({26'h0000_B01, 6'h22}, 0);
    do_fill(26'h0000_D01, 0);
    fetch(A0, 0);                 // evicted, R7
    fetch({26'h0000_D01, 6'h00}, 0);
    fetch({26'h0000_D01, 6'h10}, 1);  // flush forces full lookup, R10
    fetch({26'h0000_D01, 6'h2C}, 0);
    // R6/R9: disabled
    set_en(0);
    fetch({26'h0000_D01, 6'h04}, 0);
    do_inv(26'h0000_D01);
    set_en(1);
    fetch({26'h0000_D01, 6'h04}, 0);  // R9 invalidated while disabled
    fetch({26'h0000_C01, 6'h30}, 0);
    set_en(0);
    set_en(1);
    fetch({26'h0000_C01, 6'h31}, 0);  // R10 enable change clears tracker
    // R8 invalidate all with colliding fill
    do_fill(B0[31:6], 1);
    fetch(B0, 0);
    fetch({26'h0000_C01, 6'h00}, 0);
    // R1 back-pressure
    do_fill(B0[31:6], 0);
    rsp_ready = 0;
    fetch(B0 + 32'h3, 0);
    held = rsp_data;
    @(negedge clk);
    req_valid = 1; req_addr = B0 + 32'h20;
    #1;
    chk(req_ready == 0, "R1 stall ready", 128'(req_ready), 128'(0));
    chk(tag_rd_en == 0 && data_rd_en == 0, "R11 stalled enables",
        128'({tag_rd_en, data_rd_en}), 128'(0));
    @(posedge clk);
    #1;
    chk(rsp_valid == 1 && rsp_data == held, "R1 hold", rsp_data, held);
    req_valid = 0;
    @(negedge clk);
    rsp_ready = 1;
    @(posedge clk);
    #1;
    chk(rsp_valid == 0, "R1 drain", 128'(rsp_valid), 128'(0));

    // random mix
    prev = B0;
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [31:0] a;
      r = int'($urandom % 16);
      if ($urandom % 2 == 0) a = {prev[31:6], 6'($urandom)};
      else a = {22'h100 + 22'($urandom % 3), 4'(($urandom % 4) * 4 + 1), 6'($urandom)};
      if (r < 9) begin
        fetch(a, r == 0);
        prev = a;
      end else if (r < 12) do_fill(a[31:6], 0);
      else if (r < 14) do_inv(a[31:6]);
      else if (r == 14) begin
        if ($urandom % 4 == 0) do_inv_all();
        else fetch(a, 0);
      end else set_en(!men);
    end
    finish_run();
  end
endmodule